// File: doc/BRIEF.md
# Two-Phase Datapath Control Sequencer

The block makes a pair of non-overlapping clock phases from a fast system clock, then uses them to time the enables of a datapath arithmetic operation. Each phase is a periodic pulse train. It is set by a period, a pulse width and a start offset, all counted in system clock cycles. After an offset, a phase repeats a high pulse of the given width once per period. With the default settings the period is 50 cycles and the pulse 20 cycles. Phase 1 starts at once and phase 2 lags by 25 cycles, so the two never overlap.

A one-cycle start request in the idle state launches an arithmetic operation. The operand register output enables (A and B) open on the next rising edge of phase 1 and close when phase 1 falls. The destination load enable (C) then opens on the next rising edge of phase 2 and closes when phase 2 falls. A write-back step follows. The register file write enable opens on the next rising edge of phase 1 and stays open until phase 2 next falls. Only then does the block pulse its completion output and return to idle.

The phase outputs and the enables are registered. Each enable therefore follows the phase edge that bounds it by exactly one system clock cycle. The reset input is asynchronous and active low, and its release is synchronised internally.

Top module: `twophase_ctrl_seq`

## Requirements
- R1: While `rst_n` is low, every output (both phases, all enables, `busy_o`, `done_o`) is low.
- R2: Number the system clock rising edges after `rst_n` rises as 1, 2, 3, and so on. Cycle k is the interval after edge k+2. A phase with period P, width W and offset O is high in cycle k (k ≥ 1) exactly when m = k−1 satisfies m ≥ O and (m−O) mod P < W. It is low otherwise, including in cycle 0 and before.
- R3: The default timing is P=50 and W=20, with offset 0 for phase 1 and offset 25 for phase 2. With these values phase 2 first rises in cycle 26, and the two phases are never high in the same cycle.
- R4: `start_i` is sampled on each clock edge. It is accepted only when `busy_o` is low. Once accepted, `busy_o` is high from the next cycle through the cycle in which `done_o` is high. A start request made while busy has no effect.
- R5: After acceptance, the sequencer detects the first cycle in which phase 1 is high after being low in the cycle before. `a_oe_o` and `b_oe_o` rise together one cycle after that cycle. They fall one cycle after the first cycle in which phase 1 is low again.
- R6: After the operand window closes, `c_ld_o` rises one cycle after the next cycle in which phase 2 rises. It falls one cycle after phase 2 falls.
- R7: After the load window closes, `rf_we_o` rises one cycle after the next rise of phase 1. It stays high until one cycle after the next fall of phase 2.
- R8: `done_o` is high for exactly the one cycle after `rf_we_o` falls. The block is idle in the following cycle. At most one of the enable groups (A/B, C, register file write) is high in any cycle.
- R9: If the start request is sampled at the very edge that ends the cycle in which phase 1 rises, that rise is missed. The operand window then waits for the following rise of phase 1. With defaults and idle, a start driven in cycle 151 opens the operands in cycle 202.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; one timing unit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| start_i | input | 1 | Request to run one arithmetic operation |
| phase1_o | output | 1 | First non-overlapping phase |
| phase2_o | output | 1 | Second non-overlapping phase |
| a_oe_o | output | 1 | Operand A register output enable |
| b_oe_o | output | 1 | Operand B register output enable |
| c_ld_o | output | 1 | Destination C register load enable |
| rf_we_o | output | 1 | Register file write enable (write-back) |
| busy_o | output | 1 | High from acceptance of a start until completion |
| done_o | output | 1 | One-cycle completion pulse after write-back |

## Verification
The bench builds two copies side by side. One uses the default timing (period 50, width 20, offsets 0 and 25). The other uses a short period of 12, width 4 and offsets 2 and 8. The long timing shows the exact window cycles of R5 to R7, start requests made while busy, and the R9 case where a start lands on the phase 1 rising cycle. The short timing gives phase 1 a non-zero offset and puts many operations back to back while start is held high. Both copies are compared every cycle with a behavioural model that works from the phase formula of R2.

// File: rtl/twophase_ctrl_seq_pkg.sv
package twophase_ctrl_seq_pkg;

  // Sequencer progress through one arithmetic operation
  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_ARM_OPS = 3'd1,  // waiting for phase 1 to rise
    SQ_OPS     = 3'd2,  // A/B outputs open
    SQ_ARM_LD  = 3'd3,  // waiting for phase 2 to rise
    SQ_LOAD    = 3'd4,  // C load open
    SQ_ARM_WB  = 3'd5,  // waiting for phase 1 to rise again
    SQ_WB      = 3'd6,  // register file write open
    SQ_FINISH  = 3'd7   // completion pulse
  } seq_state_e;

  localparam int unsigned NUM_PHASES = 2;

endpackage

// File: rtl/twophase_rst_sync.sv
module twophase_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/twophase_phase_gen.sv
module twophase_phase_gen #(
  parameter int unsigned PERIOD = 50,
  parameter int unsigned WIDTH  = 20,
  parameter int unsigned OFFSET = 0
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase_o
);

  localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int unsigned OW = $clog2(OFFSET + 2);
  localparam logic        ARM_AT_RESET = (OFFSET == 0);
  localparam logic [PW-1:0] POS_LAST  = PW'(PERIOD - 1);
  localparam logic [OW-1:0] DLY_LAST  = OW'(OFFSET - 1);
  localparam logic [PW:0]   WIDTH_CMP = (PW+1)'(WIDTH);

  logic          armed_q, armed_d;
  logic [OW-1:0] dly_q,   dly_d;
  logic [PW-1:0] pos_q,   pos_d;
  logic          ph_q,    ph_d;
  logic          dly_en;
  logic          pos_en;

  // Next-state: wait out the offset, then sweep the period position
  always_comb begin
    armed_d = armed_q;
    dly_d   = dly_q;
    pos_d   = pos_q;
    ph_d    = 1'b0;
    dly_en  = 1'b0;
    pos_en  = 1'b0;
    if (armed_q) begin
      pos_en = 1'b1;
      ph_d   = ({1'b0, pos_q} < WIDTH_CMP);
      pos_d  = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
    end else begin
      dly_en = 1'b1;
      dly_d  = dly_q + 1'b1;
      if (dly_q == DLY_LAST) begin
        armed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= ARM_AT_RESET;
      dly_q   <= '0;
      pos_q   <= '0;
      ph_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      ph_q    <= ph_d;
      if (dly_en) begin
        dly_q <= dly_d;
      end
      if (pos_en) begin
        pos_q <= pos_d;
      end
    end
  end

  assign phase_o = ph_q;

  // R2: no pulse is produced while the offset is still being counted
  a_r2_quiet_during_offset: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !phase_o);

endmodule

// File: rtl/twophase_op_sequencer.sv
module twophase_op_sequencer
  import twophase_ctrl_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ph1_i,
  input  logic ph2_i,
  output logic a_oe_o,
  output logic b_oe_o,
  output logic c_ld_o,
  output logic rf_we_o,
  output logic busy_o,
  output logic done_o
);

  seq_state_e state_q, state_d;
  logic       ph1_q, ph2_q;
  logic       rise1, fall1, rise2, fall2;
  logic       state_en;

  // Phase edges seen against last cycle's level
  always_comb begin
    rise1 =  ph1_i & ~ph1_q;
    fall1 = ~ph1_i &  ph1_q;
    rise2 =  ph2_i & ~ph2_q;
    fall2 = ~ph2_i &  ph2_q;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:    if (start_i) state_d = SQ_ARM_OPS;
      SQ_ARM_OPS: if (rise1)   state_d = SQ_OPS;
      SQ_OPS:     if (fall1)   state_d = SQ_ARM_LD;
      SQ_ARM_LD:  if (rise2)   state_d = SQ_LOAD;
      SQ_LOAD:    if (fall2)   state_d = SQ_ARM_WB;
      SQ_ARM_WB:  if (rise1)   state_d = SQ_WB;
      SQ_WB:      if (fall2)   state_d = SQ_FINISH;
      SQ_FINISH:               state_d = SQ_IDLE;
      default:                 state_d = SQ_IDLE;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ph1_q   <= 1'b0;
      ph2_q   <= 1'b0;
    end else begin
      ph1_q <= ph1_i;
      ph2_q <= ph2_i;
      if (state_en) begin
        state_q <= state_d;
      end
    end
  end

  // Moore decode of the enables from the registered state
  always_comb begin
    a_oe_o  = (state_q == SQ_OPS);
    b_oe_o  = (state_q == SQ_OPS);
    c_ld_o  = (state_q == SQ_LOAD);
    rf_we_o = (state_q == SQ_WB);
    done_o  = (state_q == SQ_FINISH);
    busy_o  = (state_q != SQ_IDLE);
  end

  // R4: an idle start is taken up on the following cycle
  a_r4_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R5: operand window opens only while phase 1 was high
  a_r5_ops_open_in_p1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_oe_o) |-> $past(ph1_i));

  // R5: operand window closes right after phase 1 went low
  a_r5_ops_close_after_p1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_oe_o) |-> !$past(ph1_i));

  // R6: load window opens only while phase 2 was high
  a_r6_load_open_in_p2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_ld_o) |-> $past(ph2_i));

  // R7: write-back ends on a falling edge of phase 2
  a_r7_wb_ends_on_p2_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rf_we_o) |-> ($past(ph2_i, 2) && !$past(ph2_i)));

  // R8: completion is reported only straight after write-back
  a_r8_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rf_we_o));

  // R8: the enable groups never overlap
  a_r8_groups_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_oe_o, c_ld_o, rf_we_o}));

endmodule

// File: rtl/twophase_ctrl_seq.sv
module twophase_ctrl_seq
  import twophase_ctrl_seq_pkg::*;
#(
  parameter int unsigned PERIOD      = 50,
  parameter int unsigned WIDTH       = 20,
  parameter int unsigned OFFSET1     = 0,
  parameter int unsigned OFFSET2     = 25,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic phase1_o,
  output logic phase2_o,
  output logic a_oe_o,
  output logic b_oe_o,
  output logic c_ld_o,
  output logic rf_we_o,
  output logic busy_o,
  output logic done_o
);

  logic                  rst_sync_n;
  logic [NUM_PHASES-1:0] phase_w;

  twophase_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar gi = 0; gi < NUM_PHASES; gi++) begin : g_phase
    localparam int unsigned OFF = (gi == 0) ? OFFSET1 : OFFSET2;
    twophase_phase_gen #(
      .PERIOD (PERIOD),
      .WIDTH  (WIDTH),
      .OFFSET (OFF)
    ) u_gen (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .phase_o (phase_w[gi])
    );
  end

  twophase_op_sequencer u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .ph1_i   (phase_w[0]),
    .ph2_i   (phase_w[1]),
    .a_oe_o  (a_oe_o),
    .b_oe_o  (b_oe_o),
    .c_ld_o  (c_ld_o),
    .rf_we_o (rf_we_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign phase1_o = phase_w[0];
  assign phase2_o = phase_w[1];

  // R3: the two phases are never high together
  a_r3_phases_disjoint: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(phase1_o && phase2_o));

endmodule

// File: tb/twophase_ctrl_seq_bench.sv
module twophase_ctrl_seq_bench;

  localparam int P0 = 50, W0 = 20, O10 = 0, O20 = 25;
  localparam int P1 = 12, W1 = 4,  O11 = 2, O21 = 8;
  localparam int LAST_CYCLE = 900;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] obs [2];
  logic p1a, p2a, aa, ba, ca, wa, bya, da;
  logic p1b, p2b, ab, bb, cb, wb, byb, db;

  twophase_ctrl_seq u_twophase_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .phase1_o(p1a), .phase2_o(p2a), .a_oe_o(aa), .b_oe_o(ba),
    .c_ld_o(ca), .rf_we_o(wa), .busy_o(bya), .done_o(da));

  twophase_ctrl_seq #(.PERIOD(P1), .WIDTH(W1), .OFFSET1(O11), .OFFSET2(O21))
    u_twophase_ctrl_seq_alt (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .phase1_o(p1b), .phase2_o(p2b), .a_oe_o(ab), .b_oe_o(bb),
    .c_ld_o(cb), .rf_we_o(wb), .busy_o(byb), .done_o(db));

  assign obs[0] = {p1a, p2a, aa, ba, ca, wa, bya, da};
  assign obs[1] = {p1b, p2b, ab, bb, cb, wb, byb, db};

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic bit phase_at(int k, int per, int wid, int off);
    int m;
    m = k - 1;
    if (k < 1 || m < off) return 1'b0;
    return ((m - off) % per) < wid;
  endfunction

  // Behavioural reference: stage number 0..7 for idle, wait-op, op,
  // wait-load, load, wait-wb, wb, done
  int  stage [2];
  bit  mp1 [2], mp2 [2], mp1d [2], mp2d [2];
  int  edges = 0;
  int  cyc = 0;

  initial begin
    for (int d = 0; d < 2; d++) begin
      stage[d] = 0; mp1[d] = 0; mp2[d] = 0; mp1d[d] = 0; mp2d[d] = 0;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      edges = edges + 1;
      if (edges >= 3) begin
        cyc = edges - 2;
        for (int d = 0; d < 2; d++) begin
          bit r1, f1, r2, f2;
          int per, wid, o1, o2;
          r1 = mp1[d] && !mp1d[d];
          f1 = !mp1[d] && mp1d[d];
          r2 = mp2[d] && !mp2d[d];
          f2 = !mp2[d] && mp2d[d];
          case (stage[d])
            0: if (start) stage[d] = 1;
            1: if (r1) stage[d] = 2;
            2: if (f1) stage[d] = 3;
            3: if (r2) stage[d] = 4;
            4: if (f2) stage[d] = 5;
            5: if (r1) stage[d] = 6;
            6: if (f2) stage[d] = 7;
            default: stage[d] = 0;
          endcase
          per = (d == 0) ? P0 : P1;
          wid = (d == 0) ? W0 : W1;
          o1  = (d == 0) ? O10 : O11;
          o2  = (d == 0) ? O20 : O21;
          mp1d[d] = mp1[d];
          mp2d[d] = mp2[d];
          mp1[d]  = phase_at(cyc, per, wid, o1);
          mp2[d]  = phase_at(cyc, per, wid, o2);
        end
      end
    end
  end

  int  ops_rise [$];
  int  p1_first0 = -1, p2_first0 = -1, p1_first1 = -1;
  bit  prev_a0 = 0;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      for (int b = 0; b < 8; b++) check(obs[d][b], 1'b0, "R1", "output in reset");
    end
    rst_n = 1'b1;
    while (cyc < LAST_CYCLE) begin
      @(negedge clk);
      for (int d = 0; d < 2; d++) begin
        logic [7:0] e;
        e = {mp1[d], mp2[d], stage[d] == 2, stage[d] == 2, stage[d] == 4,
             stage[d] == 6, stage[d] != 0, stage[d] == 7};
        check(obs[d][7], e[7], "R2", $sformatf("phase1 dut%0d", d));
        check(obs[d][6], e[6], "R2", $sformatf("phase2 dut%0d", d));
        check(obs[d][5], e[5], "R5", $sformatf("a_oe dut%0d", d));
        check(obs[d][4], e[4], "R5", $sformatf("b_oe dut%0d", d));
        check(obs[d][3], e[3], "R6", $sformatf("c_ld dut%0d", d));
        check(obs[d][2], e[2], "R7", $sformatf("rf_we dut%0d", d));
        check(obs[d][1], e[1], "R4", $sformatf("busy dut%0d", d));
        check(obs[d][0], e[0], "R8", $sformatf("done dut%0d", d));
      end
      check(p1a && p2a, 1'b0, "R3", "default phases overlap");
      if (aa && !prev_a0) ops_rise.push_back(cyc);
      prev_a0 = aa;
      if (p1a && p1_first0 < 0) p1_first0 = cyc;
      if (p2a && p2_first0 < 0) p2_first0 = cyc;
      if (p1b && p1_first1 < 0) p1_first1 = cyc;
      // Start schedule: mid-pulse, while busy (R4), on the phase-1 rise cycle (R9), held high
      start = (cyc == 3) || (cyc == 60) || (cyc == 151) || (cyc >= 400 && cyc <= 700);
    end
    check_int(p1_first0, 1, "R3", "first phase1 high cycle, defaults");
    check_int(p2_first0, 26, "R3", "first phase2 high cycle, defaults");
    check_int(p1_first1, 3, "R2", "first phase1 high cycle, offset 2");
    check_int(ops_rise.size() > 0 ? ops_rise[0] : -1, 52, "R5", "first operand window start");
    check_int(ops_rise.size() > 1 ? ops_rise[1] : -1, 202, "R9", "start on rise cycle waits a period");
    summary();
  end

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
    summary();
  end

endmodule